// File: doc/BRIEF.md
# Self-clearing soft reset sequencer for two PHY ports and a virtual PHY

This block starts and times soft resets for three sub-modules: PHY port A, PHY port B and a virtual PHY. Each sub-module has two ways to request a reset. The first is its bit in a shared reset-request register. The second is the Reset bit in that sub-module's own basic-control register. Once a reset starts, the block holds that sub-module's reset output high for a fixed number of clock cycles. It then clears the request by itself, so software can poll either bit until it reads 0.

The hold times come from parameters. The PHY ports hold for a time given in microseconds, and the virtual PHY holds for a time given in nanoseconds. Both are converted to clock cycles using the clock frequency parameter, so a simulation can pick a slow clock and get short counts. The block keeps the three basic-control registers itself, and each reset source treats their fields differently:
- A request through the shared register clears every field.
- A request through the Reset bit keeps a preserved field.
- Leaving power-down on a PHY port starts a reset that changes no register at all.

The register port is a plain single-cycle write strobe with combinational read data. There is no handshake and no back-pressure: a write is taken in the cycle its strobe is high.

Top module: `soft_rst_seq`

## Requirements
- R1: After the synchronous active-low `rst_n`:
  - every hold output is 0;
  - address 0 reads 0x0000;
  - addresses 1, 2 and 3 each read 0x00A5: the config field [7:0] holds its default 0xA5, and the preserved field [13:8], power-down bit 14 and Reset bit 15 are 0.
- R2: Writing 1 to bit m of address 0 (m = 0 port A, 1 port B, 2 virtual PHY) starts a reset of sub-module m when it is idle. While that reset runs, bit m of address 0 and bit 15 of that sub-module's basic-control register both read 1.
- R3: Writing a word with bit 15 set to the basic-control register of an idle sub-module (address 1, 2 or 3) starts its reset. The rest of that written word is discarded.
- R4: A reset finishes without software action. In the cycle the hold output falls, the done output pulses high for exactly one cycle, and from then on both request bits read 0.
- R5: The hold output of a PHY port stays high for exactly PHY_RST_US × CLK_HZ/10^6 cycles. The hold output of the virtual PHY stays high for exactly VPHY_RST_NS × CLK_HZ/10^9 cycles.
- R6: A reset of one sub-module leaves the hold output and the register contents of the other two unchanged.
- R7: A reset started through bit 15 keeps the preserved field [13:8]. It returns config [7:0] to 0xA5 and the power-down bit to 0.
- R8: A reset started through address 0 returns every field of that sub-module, including the preserved field, to its default.
- R9: On a PHY port, a write that changes the power-down bit 14 from 1 to 0 (with bit 15 clear) does two things:
  - it stores the written fields as usual;
  - it starts a reset of the PHY duration that changes no register field and leaves both request bits reading 0.
- R10: While a sub-module is resetting, further requests for it are ignored: writes to its basic-control register and writes of 1 to its bit of address 0 neither alter its registers nor restart its countdown.
- R11: Bits written as 0 at address 0 have no effect. The virtual PHY has no power-down bit: its bit 14 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| addr | input | 2 | Register address for both write and read: 0 shared request, 1 port A, 2 port B, 3 virtual PHY |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| mod_hold | output | 3 | Per-sub-module reset hold, high while that reset runs |
| mod_done | output | 3 | One-cycle pulse when a sub-module's reset finishes |

## Verification
The bench checks the exact hold length of every reset against a per-sub-module queue, so a countdown that restarts on a repeated request shows up as an overlong interval, and a wrong cycle conversion shows up as a wrong count. It reads the preserved field back after each kind of reset, which catches a design that clears it on a Reset-bit request or keeps it on a shared-register request. A power-down exit must hold the port in reset while both request bits read 0 and the written fields survive. A design that reused the soft-reset path for it would wipe the configuration. Three resets launched together must finish independently, so a shared counter or cross-talk between sub-modules breaks the queue comparison.

// File: rtl/soft_rst_pkg.sv
package soft_rst_pkg;
  localparam int N_MOD   = 3;
  localparam int N_PHY   = 2;
  localparam int DW      = 16;
  localparam int RST_BIT = 15;
  localparam int PD_BIT  = 14;
  localparam int KEEP_HI = 13;
  localparam int KEEP_LO = 8;
  localparam int CFG_HI  = 7;
  localparam int KEEP_W  = KEEP_HI - KEEP_LO + 1;
  localparam int CFG_W   = CFG_HI + 1;

  typedef enum logic [1:0] {
    SRC_SHARED = 2'd0,
    SRC_BASIC  = 2'd1,
    SRC_PWRUP  = 2'd2
  } rst_src_e;
endpackage

// File: rtl/rst_countdown.sv
module rst_countdown
  import soft_rst_pkg::*;
#(
  parameter int DUR = 4,
  parameter int CW  = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  rst_src_e src_in,
  output logic     busy,
  output rst_src_e src_q,
  output logic     done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      src_q <= SRC_SHARED;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt_q <= CW'(DUR - 1);
          src_q <= src_in;
        end
      end else if (cnt_q == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && ($past(cnt_q) != '0)) |-> (cnt_q == $past(cnt_q) - CW'(1))); // R10
endmodule

// File: rtl/basic_ctl_reg.sv
module basic_ctl_reg
  import soft_rst_pkg::*;
#(
  parameter bit             HAS_PD  = 1'b1,
  parameter logic [CFG_W-1:0] CFG_DEF = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_all,
  input  logic          busy,
  input  logic          soft_busy,
  output logic          req_basic,
  output logic          req_pwrup,
  output logic [DW-1:0] rd_word
);
  logic [CFG_W-1:0]  cfg_q;
  logic [KEEP_W-1:0] keep_q;
  logic              pd_q;
  logic              wr_ok;

  assign wr_ok     = wr_sel && !busy;
  assign req_basic = wr_ok && wr_data[RST_BIT];
  assign req_pwrup = wr_ok && !wr_data[RST_BIT] && HAS_PD && pd_q && !wr_data[PD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      cfg_q  <= CFG_DEF;
      keep_q <= '0;
      pd_q   <= 1'b0;
    end else if (req_basic) begin
      cfg_q <= CFG_DEF;
      pd_q  <= 1'b0;
    end else if (wr_ok) begin
      cfg_q  <= wr_data[CFG_HI:0];
      keep_q <= wr_data[KEEP_HI:KEEP_LO];
      pd_q   <= HAS_PD ? wr_data[PD_BIT] : 1'b0;
    end
  end

  assign rd_word = {soft_busy, pd_q, keep_q, cfg_q};

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ($stable(cfg_q) && $stable(keep_q) && $stable(pd_q))); // R10
  AST_KEEP_ON_BASIC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_basic && !clr_all) |=> $stable(keep_q)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sel && !clr_all) |=> ($stable(cfg_q) && $stable(keep_q) && $stable(pd_q))); // R6
endmodule

// File: rtl/soft_rst_seq.sv
module soft_rst_seq
  import soft_rst_pkg::*;
#(
  parameter int               CLK_HZ      = 100_000_000,
  parameter int               PHY_RST_US  = 110,
  parameter int               VPHY_RST_NS = 1000,
  parameter logic [CFG_W-1:0] CFG_DEF     = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [N_MOD-1:0] mod_hold,
  output logic [N_MOD-1:0] mod_done
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int PHY_CYC    = CYC_PER_US * PHY_RST_US;
  localparam int VPHY_RAW   = (CYC_PER_US * VPHY_RST_NS) / 1000;
  localparam int VPHY_CYC   = (VPHY_RAW < 1) ? 1 : VPHY_RAW;
  localparam int MAX_CYC    = (PHY_CYC > VPHY_CYC) ? PHY_CYC : VPHY_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);

  logic              shared_wr;
  logic [N_MOD-1:0]  busy, soft_busy, req_sh, req_basic, req_pwrup, start;
  rst_src_e          src_in [N_MOD];
  rst_src_e          src_q  [N_MOD];
  logic [DW-1:0]     word   [N_MOD];

  assign shared_wr = wr_en && (addr == 2'd0);

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    localparam bit IS_PHY = (m < N_PHY);
    localparam int DUR    = IS_PHY ? PHY_CYC : VPHY_CYC;

    assign req_sh[m]    = shared_wr && wr_data[m] && !busy[m];
    assign start[m]     = req_sh[m] || req_basic[m] || req_pwrup[m];
    assign src_in[m]    = req_sh[m] ? SRC_SHARED : (req_basic[m] ? SRC_BASIC : SRC_PWRUP);
    assign soft_busy[m] = busy[m] && (src_q[m] != SRC_PWRUP);

    basic_ctl_reg #(.HAS_PD(IS_PHY), .CFG_DEF(CFG_DEF)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_en && (addr == 2'(m + 1))),
      .wr_data   (wr_data),
      .clr_all   (req_sh[m]),
      .busy      (busy[m]),
      .soft_busy (soft_busy[m]),
      .req_basic (req_basic[m]),
      .req_pwrup (req_pwrup[m]),
      .rd_word   (word[m])
    );

    rst_countdown #(.DUR(DUR), .CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start[m]),
      .src_in (src_in[m]),
      .busy   (busy[m]),
      .src_q  (src_q[m]),
      .done   (mod_done[m])
    );
  end

  assign mod_hold = busy;

  always_comb begin
    if (addr == 2'd0) rd_data = {{(DW-N_MOD){1'b0}}, soft_busy};
    else              rd_data = word[addr - 2'd1];
  end

  AST_PWRUP_NO_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pwrup != '0) |=> ((soft_busy & $past(req_pwrup)) == '0)); // R9
  AST_DONE_ONEHOT_PER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start != '0) |=> ((mod_done & $past(start)) == '0)); // R4
endmodule

// File: tb/soft_rst_seq_tb.sv
module soft_rst_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000_000;
  localparam int PHY_LEN    = 1100;
  localparam int VPHY_LEN   = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  mod_hold, mod_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_q [3][$];
  int hold_cnt [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_rst_seq #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .mod_hold(mod_hold), .mod_done(mod_done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic expect_len(input int m, input int len);
    exp_q[m].push_back(len);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: hold length per completed reset
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 3; m++) begin
        if (mod_hold[m]) hold_cnt[m]++;
        if (mod_done[m]) begin
          checks++;
          if (exp_q[m].size() == 0) begin
            errors++;
            $display("FAIL R4: module %0d done with no reset expected, actual %0d expected none", m, hold_cnt[m]);
          end else begin
            int e;
            e = exp_q[m].pop_front();
            if (hold_cnt[m] != e) begin
              errors++;
              $display("FAIL R5/R10: module %0d hold length actual %0d expected %0d", m, hold_cnt[m], e);
            end
          end
          hold_cnt[m] = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    for (int m = 0; m < 3; m++) hold_cnt[m] = 0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 hold", {13'd0, mod_hold}, 16'h0000);
    rd(2'd0, v); chk("R1 shared", v, 16'h0000);
    rd(2'd1, v); chk("R1 portA", v, 16'h00A5);
    rd(2'd2, v); chk("R1 portB", v, 16'h00A5);
    rd(2'd3, v); chk("R1 vphy", v, 16'h00A5);

    // R2 / R8 / R10 / R6 : shared reset of port A
    wr(2'd1, 16'h153C);
    rd(2'd1, v); chk("R2 portA setup", v, 16'h153C);
    expect_len(0, PHY_LEN);
    wr(2'd0, 16'h0001);
    rd(2'd0, v); chk("R2 shared bit during", v, 16'h0001);
    rd(2'd1, v); chk("R2 basic bit during", v, 16'h80A5);
    chk("R6 others idle", {13'd0, mod_hold}, 16'h0001);
    rd(2'd2, v); chk("R6 portB untouched", v, 16'h00A5);
    wr(2'd1, 16'h0011);
    wr(2'd0, 16'h0001);
    idle(200);
    wr(2'd1, 16'h8022);
    idle(PHY_LEN);
    rd(2'd0, v); chk("R4 shared clear", v, 16'h0000);
    rd(2'd1, v); chk("R8/R10 portA defaults", v, 16'h00A5);

    // R3 / R7 : basic reset of port B keeps preserved field
    wr(2'd2, 16'h2A11);
    rd(2'd2, v); chk("R3 portB setup", v, 16'h2A11);
    expect_len(1, PHY_LEN);
    wr(2'd2, 16'hBF33);
    rd(2'd2, v); chk("R3 basic bit during", v, 16'hAAA5);
    rd(2'd0, v); chk("R3 shared bit during", v, 16'h0002);
    idle(PHY_LEN + 2);
    rd(2'd2, v); chk("R7 preserved kept", v, 16'h2AA5);
    rd(2'd0, v); chk("R4 bits clear", v, 16'h0000);

    // R11 / R5 / R6 : virtual PHY
    wr(2'd3, 16'h4505);
    rd(2'd3, v); chk("R11 vphy no pd", v, 16'h0505);
    wr(2'd0, 16'h0000);
    chk("R11 zero write", {13'd0, mod_hold}, 16'h0000);
    expect_len(2, VPHY_LEN);
    wr(2'd0, 16'h0004);
    idle(VPHY_LEN + 3);
    rd(2'd3, v); chk("R8 vphy defaults", v, 16'h00A5);
    rd(2'd2, v); chk("R6 portB untouched by vphy", v, 16'h2AA5);

    // R9 : power-down exit
    wr(2'd2, 16'h6A77);
    chk("R9 pd entry no reset", {13'd0, mod_hold}, 16'h0000);
    expect_len(1, PHY_LEN);
    wr(2'd2, 16'h2A77);
    chk("R9 hold during pd exit", {13'd0, mod_hold}, 16'h0002);
    rd(2'd0, v); chk("R9 shared bit stays 0", v, 16'h0000);
    rd(2'd2, v); chk("R9 regs untouched", v, 16'h2A77);
    idle(PHY_LEN + 2);
    rd(2'd2, v); chk("R9 regs after", v, 16'h2A77);

    // R5 / R6 : all three concurrently
    expect_len(0, PHY_LEN);
    expect_len(1, PHY_LEN);
    expect_len(2, VPHY_LEN);
    wr(2'd0, 16'h0007);
    chk("R2 all holding", {13'd0, mod_hold}, 16'h0007);
    idle(VPHY_LEN + 2);
    chk("R5 vphy first", {13'd0, mod_hold}, 16'h0003);
    idle(PHY_LEN);
    rd(2'd2, v); chk("R8 portB cleared", v, 16'h00A5);

    idle(4);
    for (int m = 0; m < 3; m++) begin
      checks++;
      if (exp_q[m].size() != 0) begin
        errors++;
        $display("FAIL R4: module %0d pending resets actual %0d expected 0", m, exp_q[m].size());
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule